// File: doc/BRIEF.md
# Two-Lane ADC Word Aligner

This block sits behind a pair of deserializers that each deliver one 8-bit word per word clock from one serial lane of an ADC channel. One lane carries the upper byte of every 16-bit sample and the other carries the lower byte. The deserializer word boundary is arbitrary, so each lane's bytes can start at any of eight bit positions inside the incoming words.

During training, the ADC sends a fixed byte on both lanes. Each lane keeps a history of its three most recent words. It tests every bit offset of that history against the training byte and settles on its own offset, so the two lanes may lock at different offsets. Once locked, a lane holds its offset and slices an aligned byte out of its two newest words on every clock. The two aligned bytes are joined into a registered 16-bit sample with a valid strobe.

A synchronous training request discards both locks and starts the search again. Each ADC channel uses its own instance of the block.

Top module: `two_lane_word_aligner`

## Requirements
- R1: While `rst` is high, and in the cycle that follows it, `sample_o` is zero, `sample_valid_o` is low and `lane_lock_o` is 2'b00.
- R2: `sample_o[15:8]` comes from the lane on `msb_word_i` and `sample_o[7:0]` from the lane on `lsb_word_i`. `lane_lock_o[1]` is the lock of the upper-byte lane and `lane_lock_o[0]` that of the lower-byte lane.
- R3: Bit 7 of each input word is the earliest bit in time. A lane whose byte boundary sits d bits (0..7) into its words, so that each word holds the last d bits of the previous byte followed by the first 8-d bits of the current one, delivers the original bytes after lock.
- R4: The two lanes find their offsets independently. Every pair of skews (0..7, 0..7) on the two lanes yields correct 16-bit samples.
- R5: A lane locks on an offset k after LOCK_RUN (default 4) consecutive cycles in which k is the lowest offset whose window matches TRAIN_BYTE (default 8'hF0) in both the newest and the previous two-word window. With clean training data this happens no later than 8 words after a training request.
- R6: After lock, the offset is held and arbitrary data, including random data, does not change it. Every later sample is correct.
- R7: `sample_valid_o` is high only when both lanes are locked. With only one lane locked it stays low.
- R8: A high `train_req_i` at a clock edge clears both lock flags and `sample_valid_o` at that edge, and the search starts again.
- R9: The sample whose bytes begin in the words presented at clock edge t appears on `sample_o` after edge t+2.
- R10: A 16-bit incrementing count split over the two lanes comes out unchanged across every low-byte wrap, with no error at multiples of 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| train_req_i | input | 1 | Clears locks and restarts offset search |
| msb_word_i | input | 8 | Deserialized word from the upper-byte lane |
| lsb_word_i | input | 8 | Deserialized word from the lower-byte lane |
| sample_o | output | 16 | Aligned, joined sample |
| sample_valid_o | output | 1 | Sample valid, both lanes locked |
| lane_lock_o | output | 2 | Per-lane lock flags, bit 1 upper lane |

## Verification
A wrong offset or a history filled in the wrong order shows at the ports as wrong sample bytes within two clocks of lock. Counting data can mask this for up to 255 samples, so random data follows training. A lane that locks on a false candidate, or a lock flag that survives a training request, shows up as a wrong `lane_lock_o` or `sample_valid_o` on the first edge after the event. The sweep covers all 64 pairs of lane skews, so an offset slice that is off by one bit fails in the first data cycle for most skews.

// File: rtl/wa_pkg.sv
package wa_pkg;

    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned LANES      = 2;
    localparam int unsigned MSB_IDX    = 1;
    localparam int unsigned LSB_IDX    = 0;
    localparam int unsigned OFF_W      = $clog2(BYTE_W);
    localparam int unsigned SAMPLE_W   = LANES * BYTE_W;

    typedef logic [BYTE_W-1:0]   byte_t;
    typedef logic [OFF_W-1:0]    offset_t;
    typedef logic [SAMPLE_W-1:0] sample_t;

    // Word history of one lane: oldest word in the upper field.
    typedef struct packed {
        byte_t oldest;
        byte_t middle;
        byte_t newest;
    } hist_t;

    // Search progress of one lane.
    typedef struct packed {
        logic    locked;
        offset_t offset;
        offset_t cand;
    } search_t;

    // Take the byte that starts k bits into the earlier word.
    function automatic byte_t slip_pick(byte_t early, byte_t late, offset_t k);
        logic [2*BYTE_W-1:0] cat;
        cat = {early, late} << k;
        return cat[2*BYTE_W-1 -: BYTE_W];
    endfunction

endpackage

// File: rtl/wa_lane_history.sv
module wa_lane_history
    import wa_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  byte_t word_i,
    output hist_t hist_o
);

    hist_t hist_q;

    // The newest word always enters at the low field; older words move up.
    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
        end else begin
            hist_q.oldest <= hist_q.middle;
            hist_q.middle <= hist_q.newest;
            hist_q.newest <= word_i;
        end
    end

    assign hist_o = hist_q;

endmodule

// File: rtl/wa_offset_search.sv
module wa_offset_search
    import wa_pkg::*;
#(
    parameter int unsigned LOCK_RUN   = 4,
    parameter byte_t       TRAIN_BYTE = 8'hF0
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    restart_i,
    input  hist_t   hist_i,
    output logic    locked_o,
    output offset_t offset_o
);

    localparam int unsigned RUN_W = $clog2(LOCK_RUN + 1);

    logic [BYTE_W-1:0] hit;
    offset_t           first;
    logic              any_hit;
    logic [RUN_W-1:0]  run_q, run_next;
    search_t           st_q;

    // One comparator pair per candidate offset.
    for (genvar k = 0; k < BYTE_W; k++) begin : g_cand
        assign hit[k] =
            (slip_pick(hist_i.oldest, hist_i.middle, offset_t'(k)) == TRAIN_BYTE) &&
            (slip_pick(hist_i.middle, hist_i.newest, offset_t'(k)) == TRAIN_BYTE);
    end

    // Lowest matching offset wins.
    always_comb begin
        first = '0;
        for (int k = BYTE_W - 1; k >= 0; k--) begin
            if (hit[k]) first = offset_t'(k);
        end
    end

    assign any_hit = |hit;

    always_comb begin
        if (!any_hit)
            run_next = '0;
        else if ((run_q != '0) && (first == st_q.cand))
            run_next = run_q + 1'b1;
        else
            run_next = RUN_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst || restart_i) begin
            st_q  <= '0;
            run_q <= '0;
        end else if (!st_q.locked) begin
            run_q       <= run_next;
            st_q.cand   <= first;
            if (run_next == RUN_W'(LOCK_RUN)) begin
                st_q.locked <= 1'b1;
                st_q.offset <= first;
            end
        end
    end

    assign locked_o = st_q.locked;
    assign offset_o = st_q.offset;

endmodule

// File: rtl/wa_lane_align.sv
module wa_lane_align
    import wa_pkg::*;
#(
    parameter int unsigned LOCK_RUN   = 4,
    parameter byte_t       TRAIN_BYTE = 8'hF0
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    restart_i,
    input  byte_t   word_i,
    output byte_t   aligned_o,
    output logic    locked_o,
    output offset_t offset_o
);

    hist_t   hist;
    offset_t offset;

    wa_lane_history u_hist (
        .clk    (clk),
        .rst    (rst),
        .word_i (word_i),
        .hist_o (hist)
    );

    wa_offset_search #(
        .LOCK_RUN   (LOCK_RUN),
        .TRAIN_BYTE (TRAIN_BYTE)
    ) u_search (
        .clk       (clk),
        .rst       (rst),
        .restart_i (restart_i),
        .hist_i    (hist),
        .locked_o  (locked_o),
        .offset_o  (offset)
    );

    // Slice from the two newest words, earlier word first in time.
    assign aligned_o = slip_pick(hist.middle, hist.newest, offset);
    assign offset_o  = offset;

endmodule

// File: rtl/two_lane_word_aligner.sv
module two_lane_word_aligner
    import wa_pkg::*;
#(
    parameter int unsigned LOCK_RUN   = 4,
    parameter byte_t       TRAIN_BYTE = 8'hF0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                train_req_i,
    input  logic [BYTE_W-1:0]   msb_word_i,
    input  logic [BYTE_W-1:0]   lsb_word_i,
    output logic [SAMPLE_W-1:0] sample_o,
    output logic                sample_valid_o,
    output logic [LANES-1:0]    lane_lock_o
);

    byte_t               lane_in      [LANES];
    byte_t               lane_aligned [LANES];
    logic [LANES-1:0]    lane_lock;
    offset_t [LANES-1:0] lane_off;

    assign lane_in[MSB_IDX] = msb_word_i;
    assign lane_in[LSB_IDX] = lsb_word_i;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        wa_lane_align #(
            .LOCK_RUN   (LOCK_RUN),
            .TRAIN_BYTE (TRAIN_BYTE)
        ) u_lane (
            .clk       (clk),
            .rst       (rst),
            .restart_i (train_req_i),
            .word_i    (lane_in[g]),
            .aligned_o (lane_aligned[g]),
            .locked_o  (lane_lock[g]),
            .offset_o  (lane_off[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sample_o       <= '0;
            sample_valid_o <= 1'b0;
        end else begin
            sample_o       <= {lane_aligned[MSB_IDX], lane_aligned[LSB_IDX]};
            sample_valid_o <= (&lane_lock) && !train_req_i;
        end
    end

    assign lane_lock_o = lane_lock;

endmodule

// File: rtl/wa_checker.sv
module wa_checker
    import wa_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                train_req_i,
    input logic [SAMPLE_W-1:0] sample_o,
    input logic                sample_valid_o,
    input logic [LANES-1:0]    lane_lock_o,
    input offset_t [LANES-1:0] lane_off
);

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (lane_lock_o == '0 && !sample_valid_o && sample_o == '0));

    a_r7_valid_needs_both: assert property (@(posedge clk) disable iff (rst)
        sample_valid_o |-> (&lane_lock_o));

    a_r8_train_clears: assert property (@(posedge clk) disable iff (rst)
        train_req_i |=> (lane_lock_o == '0 && !sample_valid_o));

    a_r6_msb_offset_held: assert property (@(posedge clk) disable iff (rst)
        (lane_lock_o[MSB_IDX] && !train_req_i) |=>
            (lane_lock_o[MSB_IDX] && $stable(lane_off[MSB_IDX])));

    a_r6_lsb_offset_held: assert property (@(posedge clk) disable iff (rst)
        (lane_lock_o[LSB_IDX] && !train_req_i) |=>
            (lane_lock_o[LSB_IDX] && $stable(lane_off[LSB_IDX])));

    a_r5_lock_not_on_train: assert property (@(posedge clk) disable iff (rst)
        $rose(lane_lock_o[LSB_IDX]) |-> !$past(train_req_i));

endmodule

bind two_lane_word_aligner wa_checker u_chk (
    .clk            (clk),
    .rst            (rst),
    .train_req_i    (train_req_i),
    .sample_o       (sample_o),
    .sample_valid_o (sample_valid_o),
    .lane_lock_o    (lane_lock_o),
    .lane_off       (lane_off)
);

// File: tb/tb_two_lane_word_aligner.sv
module tb_two_lane_word_aligner;
    import wa_pkg::*;

    localparam byte_t       PAT      = 8'hF0;
    localparam int unsigned LOCK_RUN = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic        train;
    byte_t       msb_w, lsb_w;
    logic [15:0] sample;
    logic        valid;
    logic [1:0]  lock;

    always #2 clk = ~clk;

    two_lane_word_aligner #(.LOCK_RUN(LOCK_RUN), .TRAIN_BYTE(PAT)) dut (
        .clk            (clk),
        .rst            (rst),
        .train_req_i    (train),
        .msb_word_i     (msb_w),
        .lsb_word_i     (lsb_w),
        .sample_o       (sample),
        .sample_valid_o (valid),
        .lane_lock_o    (lock)
    );

    int          checks = 0;
    int          errors = 0;
    bit          done   = 0;
    int          dly_m  = 0;
    int          dly_l  = 0;
    byte_t       prev_m = PAT;
    byte_t       prev_l = PAT;
    logic [15:0] q1 = '0, q2 = '0, exp_now = '0;

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One word clock: skewed words built from the byte streams, then sample.
    task automatic push(input byte_t bm, input byte_t bl, input bit tr);
        logic [15:0] cm, cl;
        cm    = {prev_m, bm} >> dly_m;
        cl    = {prev_l, bl} >> dly_l;
        msb_w = cm[7:0];
        lsb_w = cl[7:0];
        train = tr;
        @(posedge clk);
        @(negedge clk);
        exp_now = q2;
        q2      = q1;
        q1      = {bm, bl};
        prev_m  = bm;
        prev_l  = bl;
    endtask

    task automatic retrain(input int dm, input int dl);
        int n;
        dly_m = dm;
        dly_l = dl;
        push(PAT, PAT, 1'b1);
        check(lock == 2'b00 && !valid, "R8 train clears", {lock, valid}, 3'b000);
        n = 0;
        while (lock != 2'b11 && n < 16) begin
            push(PAT, PAT, 1'b0);
            n++;
        end
        check(lock == 2'b11 && n <= LOCK_RUN + 4, "R5 lock time", n, LOCK_RUN + 4);
    endtask

    initial begin
        rst   = 1'b1;
        train = 1'b0;
        msb_w = '0;
        lsb_w = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(sample == 16'h0 && !valid && lock == 2'b00, "R1 reset state",
              {sample, valid, lock}, 0);
        rst = 1'b0;
        push(PAT, PAT, 1'b0);
        check(sample == 16'h0 && !valid && lock == 2'b00, "R1 after reset",
              {sample, valid, lock}, 0);

        // R3 R4 R6 R9: every skew pair, random data after training.
        for (int dm = 0; dm < 8; dm++) begin
            for (int dl = 0; dl < 8; dl++) begin
                retrain(dm, dl);
                for (int i = 0; i < 20; i++) begin
                    push(8'($urandom), 8'($urandom), 1'b0);
                    check(valid, "R7 valid when locked", valid, 1);
                    check(sample == exp_now, "R3 R4 R6 R9 sample",
                          sample, exp_now);
                end
            end
        end

        // R2: upper byte from the msb lane only, with fixed distinct bytes.
        retrain(2, 6);
        for (int i = 0; i < 4; i++) push(8'hA5, 8'h3C, 1'b0);
        check(sample == 16'hA53C, "R2 lane mapping", sample, 16'hA53C);

        // R7: only the msb lane sees the training byte.
        push(PAT, 8'hAA, 1'b1);
        for (int i = 0; i < 16; i++) begin
            push(PAT, 8'hAA, 1'b0);
            if (i >= 10) begin
                check(lock == 2'b10, "R7 single lane lock", lock, 2'b10);
                check(!valid, "R7 no valid with one lane", valid, 0);
            end
        end

        // R10: counter across low-byte wraps.
        retrain(5, 3);
        for (int c = 0; c < 700; c++) begin
            logic [15:0] cv;
            cv = 16'(c + 16'hFF00);
            push(cv[15:8], cv[7:0], 1'b0);
            check(valid && sample == exp_now, "R10 counter", sample, exp_now);
        end

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule